// File: doc/BRIEF.md
# Guarded One-Time-Programmable Fuse Controller

This block sits between a word-wide register bus and a small bank of one-time-programmable fuse words. Two paths reach the same bank. A read-only window maps every fuse word to its own bus address, so plain loads can fetch identifiers and calibration values. A guarded path runs commands: software writes a command word that holds a fuse offset, an unlock byte and a read or burn request. It then polls the control register until the request bit drops, and collects a read result from a result register.

Burning is modelled as a bitwise OR, so a fuse bit that is set stays set. The fuse bank is a register bank that reset loads with a fixed power-on pattern. Typical contents are a 16-byte identifier at fuse offsets 0x00 to 0x0F and calibration bytes from fuse offset 0x34, read in 4-byte steps.

Top module: `otp_guard_ctrl`

## Requirements
- R1: Byte addresses 0x200 to 0x2FF form a read-only window: address 0x200+N (N = 0..255, low two bits ignored) returns fuse word N>>2, with the lowest fuse byte in bits [7:0]. Reset loads fuse word i with INIT_SEED ^ {4{i[7:0]}} (default INIT_SEED 0x12340000).
- R2: A write to the control register at 0x40 is accepted only if wdata[15:8] equals 0xAC. Any other unlock byte leaves both command bits clear and changes nothing.
- R3: In an accepted control write, wdata[23:16] is the fuse offset, bit 1 requests a read and bit 0 requests a burn. If both bits are set, only the read runs. Reading 0x40 returns the latched offset in [23:16], the read-busy bit in bit 1 and the burn-busy bit in bit 0, with all other bits zero. The two busy bits are never set together.
- R4: After the accepting clock edge, the command bit reads 1 for exactly RD_LAT cycles for a read (default 4) or PG_LAT cycles for a burn (default 6). It then clears by itself.
- R5: When a read completes, the result register at 0x60 holds fuse word offset[7:2]. The two low offset bits are ignored.
- R6: When a burn completes, fuse word offset[7:2] becomes old value OR the burn-data register at 0x50. Bits can only go from 0 to 1. The register at 0x50 reads back its value.
- R7: While a command is running, writes to 0x40 and 0x50 are ignored.
- R8: Reads of any other address return zero. Writes to 0x60 or to the window have no effect.
- R9: After reset, registers 0x40, 0x50 and 0x60 read zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| addr | input | ADDR_W | Byte address of the bus access |
| wr_en | input | 1 | Write strobe, sampled on the rising edge |
| wdata | input | DATA_W | Write data |
| rdata | output | DATA_W | Read data, a combinational decode of registered state |

## Verification
Read data is combinational from registered state. A window read or a register readback is therefore due in the same cycle as the address, and a register write shows up in the cycle after its edge. A command bit is due to read 1 from the cycle after the accepting edge until RD_LAT or PG_LAT edges have passed. The result word and the burned fuse word are due in the cycle after that last edge. The bench drives on falling edges and samples one falling edge after each edge it counts, so every check lands on the cycle in which its result is due.

// File: rtl/otp_pkg.sv
package otp_pkg;
    localparam int SLOT_W      = 6;
    localparam int CTRL_BYTE   = 'h040;
    localparam int PGD_BYTE    = 'h050;
    localparam int RDD_BYTE    = 'h060;
    localparam int WIN_BYTE    = 'h200;
    localparam logic [7:0] UNLOCK_KEY = 8'hAC;
    localparam int KEY_LO      = 8;
    localparam int OFF_LO      = 16;
    localparam int RD_BIT      = 1;
    localparam int PG_BIT      = 0;
endpackage

// File: rtl/otp_fuse_bank.sv
module otp_fuse_bank
    import otp_pkg::*;
#(
    parameter int          DATA_W     = 32,
    parameter int          FUSE_WORDS = 64,
    parameter logic [31:0] INIT_SEED  = 32'h1234_0000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [SLOT_W-1:0] win_idx,
    output logic [DATA_W-1:0] win_data,
    input  logic [SLOT_W-1:0] cmd_idx,
    output logic [DATA_W-1:0] cmd_data,
    input  logic              pg_en,
    input  logic [DATA_W-1:0] pg_mask
);
    logic [DATA_W-1:0] words [FUSE_WORDS];

    for (genvar w = 0; w < FUSE_WORDS; w++) begin : g_word
        localparam logic [DATA_W-1:0] INIT_W =
            DATA_W'(INIT_SEED) ^ {(DATA_W/8){8'(w)}};
        logic [DATA_W-1:0] word_d, word_q;

        always_comb begin
            word_d = word_q;
            if (pg_en && cmd_idx == SLOT_W'(w)) begin
                word_d = word_q | pg_mask;
            end
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) word_q <= INIT_W;
            else        word_q <= word_d;
        end

        assign words[w] = word_q;
    end

    always_comb begin
        win_data = '0;
        cmd_data = '0;
        for (int i = 0; i < FUSE_WORDS; i++) begin
            if (win_idx == SLOT_W'(i)) win_data = words[i];
            if (cmd_idx == SLOT_W'(i)) cmd_data = words[i];
        end
    end
endmodule

// File: rtl/otp_cmd_seq.sv
module otp_cmd_seq
    import otp_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int RD_LAT = 4,
    parameter int PG_LAT = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ctrl_wr,
    input  logic              pgd_wr,
    input  logic [DATA_W-1:0] wdata,
    input  logic [DATA_W-1:0] fuse_rdata,
    output logic [SLOT_W-1:0] fuse_idx,
    output logic              pg_en,
    output logic [DATA_W-1:0] pg_mask,
    output logic [DATA_W-1:0] ctrl_val,
    output logic [DATA_W-1:0] rdd_val,
    output logic              busy,
    output logic [1:0]        cmd_bits,
    output logic [7:0]        cur_off
);
    localparam int MAX_LAT = (RD_LAT > PG_LAT) ? RD_LAT : PG_LAT;
    localparam int CNT_W   = $clog2(MAX_LAT + 1);

    typedef struct packed {
        logic              rd_busy;
        logic              pg_busy;
        logic [7:0]        off;
        logic [CNT_W-1:0]  cnt;
        logic [DATA_W-1:0] pgd;
        logic [DATA_W-1:0] rdd;
    } seq_t;

    seq_t s_d, s_q;
    logic key_ok;

    assign key_ok = (wdata[KEY_LO +: 8] == UNLOCK_KEY);
    assign busy   = s_q.rd_busy | s_q.pg_busy;

    always_comb begin
        s_d   = s_q;
        pg_en = 1'b0;
        if (busy) begin
            if (s_q.cnt == '0) begin
                if (s_q.rd_busy) s_d.rdd = fuse_rdata;
                pg_en       = s_q.pg_busy;
                s_d.rd_busy = 1'b0;
                s_d.pg_busy = 1'b0;
            end else begin
                s_d.cnt = s_q.cnt - 1'b1;
            end
        end else begin
            if (pgd_wr) s_d.pgd = wdata;
            if (ctrl_wr && key_ok && (wdata[RD_BIT] || wdata[PG_BIT])) begin
                s_d.off = wdata[OFF_LO +: 8];
                if (wdata[RD_BIT]) begin
                    s_d.rd_busy = 1'b1;
                    s_d.cnt     = CNT_W'(RD_LAT - 1);
                end else begin
                    s_d.pg_busy = 1'b1;
                    s_d.cnt     = CNT_W'(PG_LAT - 1);
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign fuse_idx = s_q.off[7:2];
    assign pg_mask  = s_q.pgd;
    assign rdd_val  = s_q.rdd;
    assign cmd_bits = {s_q.rd_busy, s_q.pg_busy};
    assign cur_off  = s_q.off;
    assign ctrl_val = {{(DATA_W-24){1'b0}}, s_q.off, 14'd0, s_q.rd_busy, s_q.pg_busy};
endmodule

// File: rtl/otp_guard_ctrl.sv
module otp_guard_ctrl
    import otp_pkg::*;
#(
    parameter int          ADDR_W     = 12,
    parameter int          DATA_W     = 32,
    parameter int          FUSE_WORDS = 64,
    parameter int          RD_LAT     = 4,
    parameter int          PG_LAT     = 6,
    parameter logic [31:0] INIT_SEED  = 32'h1234_0000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata
);
    localparam int WA_W = ADDR_W - 2;
    localparam logic [WA_W-1:0] CTRL_WA = WA_W'(CTRL_BYTE >> 2);
    localparam logic [WA_W-1:0] PGD_WA  = WA_W'(PGD_BYTE  >> 2);
    localparam logic [WA_W-1:0] RDD_WA  = WA_W'(RDD_BYTE  >> 2);
    localparam logic [ADDR_W-9:0] WIN_PG = (ADDR_W-8)'(WIN_BYTE >> 8);

    logic              ctrl_hit, pgd_hit, rdd_hit, win_hit;
    logic [SLOT_W-1:0] win_idx, fuse_idx;
    logic [DATA_W-1:0] win_data, fuse_cmd_data, pg_mask, ctrl_val, rdd_val;
    logic              pg_en, seq_busy;
    logic [1:0]        cmd_bits;
    logic [7:0]        cur_off;
    logic              unused_lowaddr;

    assign unused_lowaddr = ^addr[1:0];
    assign ctrl_hit = (addr[ADDR_W-1:2] == CTRL_WA);
    assign pgd_hit  = (addr[ADDR_W-1:2] == PGD_WA);
    assign rdd_hit  = (addr[ADDR_W-1:2] == RDD_WA);
    assign win_hit  = (addr[ADDR_W-1:8] == WIN_PG);
    assign win_idx  = addr[7:2];

    otp_fuse_bank #(
        .DATA_W(DATA_W), .FUSE_WORDS(FUSE_WORDS), .INIT_SEED(INIT_SEED)
    ) u_bank (
        .clk(clk), .rst_n(rst_n),
        .win_idx(win_idx), .win_data(win_data),
        .cmd_idx(fuse_idx), .cmd_data(fuse_cmd_data),
        .pg_en(pg_en), .pg_mask(pg_mask)
    );

    otp_cmd_seq #(
        .DATA_W(DATA_W), .RD_LAT(RD_LAT), .PG_LAT(PG_LAT)
    ) u_seq (
        .clk(clk), .rst_n(rst_n),
        .ctrl_wr(wr_en && ctrl_hit), .pgd_wr(wr_en && pgd_hit),
        .wdata(wdata), .fuse_rdata(fuse_cmd_data), .fuse_idx(fuse_idx),
        .pg_en(pg_en), .pg_mask(pg_mask), .ctrl_val(ctrl_val),
        .rdd_val(rdd_val), .busy(seq_busy), .cmd_bits(cmd_bits),
        .cur_off(cur_off)
    );

    always_comb begin
        rdata = '0;
        if (ctrl_hit)     rdata = ctrl_val;
        else if (pgd_hit) rdata = pg_mask;
        else if (rdd_hit) rdata = rdd_val;
        else if (win_hit) rdata = win_data;
    end
endmodule

// File: rtl/otp_guard_chk.sv
module otp_guard_chk #(
    parameter int ADDR_W = 12,
    parameter int DATA_W = 32,
    parameter int RD_LAT = 4,
    parameter int PG_LAT = 6
) (
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W-1:0] addr,
    input logic              wr_en,
    input logic [7:0]        key,
    input logic [DATA_W-1:0] rdata,
    input logic              busy,
    input logic [1:0]        cmd_bits,
    input logic [7:0]        cur_off,
    input logic              pg_en,
    input logic [DATA_W-1:0] fuse_word
);
    localparam int MAX_LAT = (RD_LAT > PG_LAT) ? RD_LAT : PG_LAT;
    localparam int RUN_W   = $clog2(MAX_LAT + 2);
    localparam logic [ADDR_W-1:0] A_CTRL = ADDR_W'('h040);
    localparam logic [ADDR_W-1:0] A_PGD  = ADDR_W'('h050);
    localparam logic [ADDR_W-1:0] A_RDD  = ADDR_W'('h060);
    localparam logic [ADDR_W-1:0] A_WLO  = ADDR_W'('h200);
    localparam logic [ADDR_W-1:0] A_WHI  = ADDR_W'('h300);

    logic [ADDR_W-1:0] aw;
    logic              is_ctrl, unmapped;
    logic [RUN_W-1:0]  run_len;

    assign aw       = {addr[ADDR_W-1:2], 2'b00};
    assign is_ctrl  = (aw == A_CTRL);
    assign unmapped = (aw != A_CTRL) && (aw != A_PGD) && (aw != A_RDD) &&
                      ((aw < A_WLO) || (aw >= A_WHI));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)    run_len <= '0;
        else if (busy) run_len <= run_len + 1'b1;
        else           run_len <= '0;
    end

    // R3
    cmd_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(cmd_bits));

    // R2
    bad_key_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && is_ctrl && !busy && key != 8'hAC) |=> !busy);

    // R7
    busy_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && is_ctrl && busy) |=> $stable(cur_off));

    // R6
    prog_mono_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pg_en |=> ((fuse_word & $past(fuse_word)) == $past(fuse_word)));

    // R8
    unmapped_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        unmapped |-> (rdata == '0));

    // R4
    busy_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
        run_len <= RUN_W'(MAX_LAT));
endmodule

bind otp_guard_ctrl otp_guard_chk #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .RD_LAT(RD_LAT), .PG_LAT(PG_LAT)
) u_chk (
    .clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(wr_en),
    .key(wdata[15:8]), .rdata(rdata), .busy(seq_busy),
    .cmd_bits(cmd_bits), .cur_off(cur_off), .pg_en(pg_en),
    .fuse_word(fuse_cmd_data)
);

// File: tb/tb_otp_guard_ctrl.sv
module tb_otp_guard_ctrl;
    localparam int RD_LAT = 4;
    localparam int PG_LAT = 6;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [11:0] addr = '0;
    logic        wr_en = 1'b0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    otp_guard_ctrl #(.RD_LAT(RD_LAT), .PG_LAT(PG_LAT)) dut (
        .clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(wr_en),
        .wdata(wdata), .rdata(rdata)
    );

    function automatic logic [31:0] fuse_init(int i);
        return 32'h1234_0000 ^ {4{8'(i)}};
    endfunction

    // window table: {address, expected word}
    localparam logic [43:0] WIN_VEC [10] = '{
        {12'h200, 32'h1234_0000},
        {12'h201, 32'h1234_0000},
        {12'h204, 32'h1335_0101},
        {12'h20C, 32'h1137_0303},
        {12'h234, 32'h1F39_0D0D},
        {12'h2FC, 32'h2D0B_3F3F},
        {12'h300, 32'h0000_0000},
        {12'h1FC, 32'h0000_0000},
        {12'h044, 32'h0000_0000},
        {12'h7FC, 32'h0000_0000}
    };

    task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%08h expected=%08h", tag, act, exp);
        end
    endtask

    task automatic bus_wr(logic [11:0] a, logic [31:0] d);
        addr = a; wdata = d; wr_en = 1'b1;
        @(posedge clk);
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic bus_rd(logic [11:0] a, output logic [31:0] d);
        addr = a; wr_en = 1'b0;
        #1 d = rdata;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog actual=hung expected=finished");
        finish_run();
    end

    initial begin
        logic [31:0] v;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R9 reset state
        bus_rd(12'h040, v); check("R9 ctrl after reset", v, 32'h0);
        bus_rd(12'h050, v); check("R9 pgdata after reset", v, 32'h0);
        bus_rd(12'h060, v); check("R9 result after reset", v, 32'h0);

        // R1 / R8 window table
        for (int k = 0; k < 10; k++) begin
            bus_rd(WIN_VEC[k][43:32], v);
            check($sformatf("R1/R8 window addr %03h", WIN_VEC[k][43:32]),
                  v, WIN_VEC[k][31:0]);
        end

        // R4 R5 protected read of calibration word at offset 0x34
        bus_wr(12'h040, 32'h0034_AC02);
        for (int j = 0; j < RD_LAT; j++) begin
            bus_rd(12'h040, v); check("R4 read busy", v, 32'h0034_0002);
            @(negedge clk);
        end
        bus_rd(12'h040, v); check("R4 read bit cleared", v, 32'h0034_0000);
        bus_rd(12'h060, v); check("R5 result offset 34", v, fuse_init(13));

        // R5 low offset bits ignored
        bus_wr(12'h040, 32'h0007_AC02);
        repeat (RD_LAT) @(negedge clk);
        bus_rd(12'h060, v); check("R5 offset 07 reads word 1", v, fuse_init(1));

        // R2 wrong unlock byte
        bus_wr(12'h040, 32'h0000_AB02);
        bus_rd(12'h040, v); check("R2 bad key ignored", v, 32'h0004_0000 | 32'h0003_0000);
        bus_rd(12'h060, v); check("R2 result unchanged", v, fuse_init(1));

        // R3 both bits: only read runs
        bus_wr(12'h040, 32'h000C_AC03);
        bus_rd(12'h040, v); check("R3 both bits read only", v, 32'h000C_0002);
        // R7 control write while busy ignored
        bus_wr(12'h040, 32'h0010_AC02);
        bus_rd(12'h040, v); check("R7 busy ctrl write ignored", v, 32'h000C_0002);
        repeat (RD_LAT) @(negedge clk);
        bus_rd(12'h060, v); check("R3 read result word 3", v, fuse_init(3));
        bus_rd(12'h2FC, v); check("R3 no burn happened", v, fuse_init(63));

        // R6 burn
        bus_wr(12'h050, 32'h0000_F00F);
        bus_rd(12'h050, v); check("R6 pgdata readback", v, 32'h0000_F00F);
        bus_wr(12'h040, 32'h0008_AC01);
        bus_wr(12'h050, 32'hFFFF_FFFF);  // R7 ignored while busy
        bus_rd(12'h050, v); check("R7 pgdata write ignored", v, 32'h0000_F00F);
        for (int j = 1; j < PG_LAT; j++) begin
            bus_rd(12'h040, v); check("R4 burn busy", v, 32'h0008_0001);
            @(negedge clk);
        end
        bus_rd(12'h040, v); check("R4 burn bit cleared", v, 32'h0008_0000);
        bus_rd(12'h208, v); check("R6 burned word", v, fuse_init(2) | 32'h0000_F00F);

        // R6 burning zeros clears nothing
        bus_wr(12'h050, 32'h0000_0000);
        bus_wr(12'h040, 32'h0008_AC01);
        repeat (PG_LAT) @(negedge clk);
        bus_rd(12'h208, v); check("R6 no bit cleared", v, fuse_init(2) | 32'h0000_F00F);
        bus_wr(12'h040, 32'h0008_AC02);
        repeat (RD_LAT) @(negedge clk);
        bus_rd(12'h060, v); check("R5 read burned word", v, fuse_init(2) | 32'h0000_F00F);

        // R8 writes to read-only addresses
        bus_wr(12'h060, 32'hDEAD_BEEF);
        bus_rd(12'h060, v); check("R8 result write ignored", v, fuse_init(2) | 32'h0000_F00F);
        bus_wr(12'h204, 32'hFFFF_FFFF);
        bus_rd(12'h204, v); check("R8 window write ignored", v, fuse_init(1));

        // R9 reset restores power-on pattern
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        bus_rd(12'h208, v); check("R9 fuse reload", v, fuse_init(2));
        bus_rd(12'h050, v); check("R9 pgdata cleared", v, 32'h0);

        finish_run();
    end
endmodule